// File: doc/BRIEF.md
# Serial Control Word Transmitter

This block sits on the host side of a three-wire serial control link. It takes an 11-bit control word and a one-cycle start strobe. It then produces the serial clock, serial data and latch waveforms that shift the word into a remote receiver and commit it. The receiver samples data on each rising edge of the serial clock and copies its shift register to its outputs when the latch rises. Every interval of the waveform is counted in system-clock cycles, and the counts are parameters. The defaults give at least 1 µs per interval at 100 MHz, so the serial clock stays at or below 500 kHz.

The transmitter lowers the latch when a frame begins and sends the word least-significant bit first. Data changes only on falling edges of the serial clock. On the last bit the clock stays high and the latch rises inside that high phase. The clock falls only after a further hold interval. A one-cycle done pulse ends the frame once the latch has been high for its minimum width.

Separately, a reset request issued while idle drives an active-low target reset for a programmable width. This is normally done once, before the first frame. The block reports busy for both operations.

Top module: `sctl_tx`

## Requirements
- R1: After reset and whenever not busy, the outputs rest at serial clock 0, data 0, latch 1, target reset 1, busy 0 and done 0.
- R2: A start seen while idle (and without a reset request) captures `word_i`, lowers the latch and raises busy at the next clock edge.
- R3: The frame carries 11 bits. Bit `word_i[0]` is sent first and `word_i[10]` last. Each bit is valid at a rising edge of the serial clock.
- R4: Each bit's clock-low phase lasts max(HALF_CYC, SETUP_CYC) cycles, and data stays constant through it (setup before the rising edge).
- R5: Each clock-high phase of bits 1 to 10 lasts max(HALF_CYC, HOLD_CYC) cycles. Data changes only in the cycle the clock falls (hold after the rising edge).
- R6: On the 11th bit the latch rises LSU_CYC cycles after the clock rose, while the clock is still high. The clock falls LATHD_CYC cycles after the latch rose.
- R7: Done is high for exactly one cycle, LATREST_CYC cycles after the final clock fall. Busy clears in that same cycle, with the latch high and the clock low.
- R8: A start while busy is ignored: the frame in progress keeps its captured word and its timing.
- R9: A reset request while idle drives `tgt_rst_n_o` low for RSTW_CYC cycles with busy high. It wins over a start given in the same cycle, and that start is dropped.
- R10: Data returns to 0 in the cycle the final clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (one cycle) |
| word_i | input | NB | Control word; bit 0 is sent first |
| rst_req | input | 1 | Request a target reset pulse |
| sclk_o | output | 1 | Serial clock to the receiver |
| sdata_o | output | 1 | Serial data to the receiver |
| slat_o | output | 1 | Latch strobe to the receiver |
| tgt_rst_n_o | output | 1 | Active-low reset to the receiver |
| busy_o | output | 1 | Frame or reset pulse in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The embedded properties check every cycle that data never moves while the serial clock is high or during a low phase, and that the latch rises only inside a clock-high phase. They also check that the clock falls only after the latch is already high, that done is a lone pulse coinciding with the idle levels, and that the target reset is low only while busy. The exact phase lengths, the bit order, the dropping of starts during a frame and the priority of a reset request over a start are shown only by the bench scenarios. There, a behavioural waveform model predicts every output on every cycle, and the received words are rebuilt from the rising clock edges.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RPULSE, ST_LOW, ST_HIGH, ST_LSU, ST_LHD, ST_REST
  } sctl_st_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sctl_cnt.sv
module sctl_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sctl_word.sv
module sctl_word #(
  parameter int unsigned NB = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic          adv,
  input  logic [NB-1:0] word_i,
  output logic          bit_nxt,
  output logic          last
);
  localparam int unsigned IW = $clog2(NB);

  logic [NB-1:0] word_q;
  logic [IW-1:0] idx_q;
  logic [NB-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (cap) begin
      word_q <= word_i;
      idx_q  <= '0;
    end else if (adv) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign sh      = word_q >> (32'(idx_q) + 32'd1);
  assign bit_nxt = sh[0];
  assign last    = (idx_q == IW'(NB - 1));
endmodule

// File: rtl/sctl_tx.sv
module sctl_tx #(
  parameter int unsigned NB          = 11,
  parameter int unsigned HALF_CYC    = 100,
  parameter int unsigned SETUP_CYC   = 100,
  parameter int unsigned HOLD_CYC    = 100,
  parameter int unsigned LSU_CYC     = 200,
  parameter int unsigned LATHD_CYC   = 100,
  parameter int unsigned LATREST_CYC = 100,
  parameter int unsigned RSTW_CYC    = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NB-1:0] word_i,
  input  logic          rst_req,
  output logic          sclk_o,
  output logic          sdata_o,
  output logic          slat_o,
  output logic          tgt_rst_n_o,
  output logic          busy_o,
  output logic          done_o
);
  import sctl_pkg::*;

  localparam int unsigned LO_LEN = umax(HALF_CYC, SETUP_CYC);
  localparam int unsigned HI_LEN = umax(HALF_CYC, HOLD_CYC);
  localparam int unsigned MAXC   = umax(umax(umax(LO_LEN, HI_LEN), umax(LSU_CYC, LATHD_CYC)),
                                        umax(LATREST_CYC, RSTW_CYC));
  localparam int unsigned CW     = $clog2(MAXC + 1);

  sctl_st_e      st_q;
  logic          sclk_q, sdata_q, slat_q, trst_n_q, busy_q, done_q;
  logic          zero, load, cap, adv, bit_nxt, last;
  logic [CW-1:0] val;

  sctl_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .val(val), .zero(zero)
  );

  sctl_word #(.NB(NB)) u_word (
    .clk(clk), .rst(rst), .cap(cap), .adv(adv), .word_i(word_i),
    .bit_nxt(bit_nxt), .last(last)
  );

  assign cap = (st_q == ST_IDLE) && !rst_req && start;
  assign adv = (st_q == ST_HIGH) && zero;

  always_comb begin
    load = 1'b0;
    val  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (rst_req)    begin load = 1'b1; val = CW'(RSTW_CYC - 1); end
        else if (start) begin load = 1'b1; val = CW'(LO_LEN - 1);   end
      end
      ST_LOW:  if (zero) begin load = 1'b1; val = last ? CW'(LSU_CYC - 1) : CW'(HI_LEN - 1); end
      ST_HIGH: if (zero) begin load = 1'b1; val = CW'(LO_LEN - 1);      end
      ST_LSU:  if (zero) begin load = 1'b1; val = CW'(LATHD_CYC - 1);   end
      ST_LHD:  if (zero) begin load = 1'b1; val = CW'(LATREST_CYC - 1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      sclk_q   <= 1'b0;
      sdata_q  <= 1'b0;
      slat_q   <= 1'b1;
      trst_n_q <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (rst_req) begin
            st_q <= ST_RPULSE; trst_n_q <= 1'b0; busy_q <= 1'b1;
          end else if (start) begin
            st_q <= ST_LOW; sdata_q <= word_i[0]; slat_q <= 1'b0; busy_q <= 1'b1;
          end
        end
        ST_RPULSE: if (zero) begin
          st_q <= ST_IDLE; trst_n_q <= 1'b1; busy_q <= 1'b0;
        end
        ST_LOW: if (zero) begin
          sclk_q <= 1'b1;
          st_q   <= last ? ST_LSU : ST_HIGH;
        end
        ST_HIGH: if (zero) begin
          sclk_q <= 1'b0; sdata_q <= bit_nxt; st_q <= ST_LOW;
        end
        ST_LSU: if (zero) begin
          slat_q <= 1'b1; st_q <= ST_LHD;
        end
        ST_LHD: if (zero) begin
          sclk_q <= 1'b0; sdata_q <= 1'b0; st_q <= ST_REST;
        end
        ST_REST: if (zero) begin
          done_q <= 1'b1; busy_q <= 1'b0; st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o      = sclk_q;
  assign sdata_o     = sdata_q;
  assign slat_o      = slat_q;
  assign tgt_rst_n_o = trst_n_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  a_r1_idle_levels: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!sclk_q && slat_q && !sdata_q && trst_n_q));
  a_r4_setup_stable: assert property (@(posedge clk) disable iff (rst)
    (!sclk_q && $past(!sclk_q) && !slat_q && $past(!slat_q)) |-> $stable(sdata_q));
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && $past(sclk_q)) |-> $stable(sdata_q));
  a_r6_latch_in_high: assert property (@(posedge clk) disable iff (rst)
    $rose(slat_q) |-> sclk_q);
  a_r6_fall_after_latch: assert property (@(posedge clk) disable iff (rst)
    ($fell(sclk_q) && slat_q) |-> $past(slat_q));
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r7_done_levels: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (slat_q && !sclk_q && !busy_q));
  a_r9_reset_busy: assert property (@(posedge clk) disable iff (rst)
    !trst_n_q |-> (busy_q && !sclk_q && slat_q));
endmodule

// File: tb/tb_sctl_tx.sv
module tb_sctl_tx;
  localparam int NB = 11;
  localparam int HALF = 3, SETUP = 4, HOLD = 2, LSU = 5, LATHD = 2, LATREST = 3, RSTW = 6;
  localparam int LO = (HALF > SETUP) ? HALF : SETUP;
  localparam int HI = (HALF > HOLD) ? HALF : HOLD;
  // field order: sclk, sdata, slat, busy, done, tgt_rst_n
  localparam logic [5:0] IDLE_V = 6'b001001;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, rst_req = 1'b0;
  logic [NB-1:0] word = '0;
  logic sclk_o, sdata_o, slat_o, tgt_rst_n_o, busy_o, done_o;

  int checks = 0, failures = 0, cycles = 0;
  logic [5:0] q[$];
  logic [5:0] exp_v = IDLE_V;
  logic [NB-1:0] sent_w = '0, rx = '0;
  logic prev_sclk = 1'b0;
  int nbits = 0;

  always #5 clk = ~clk;

  sctl_tx #(.NB(NB), .HALF_CYC(HALF), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .LSU_CYC(LSU),
            .LATHD_CYC(LATHD), .LATREST_CYC(LATREST), .RSTW_CYC(RSTW)) dut (
    .clk(clk), .rst(rst), .start(start), .word_i(word), .rst_req(rst_req),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .slat_o(slat_o), .tgt_rst_n_o(tgt_rst_n_o),
    .busy_o(busy_o), .done_o(done_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // behavioural waveform model (R2..R10), one entry per system clock cycle
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      exp_v = IDLE_V;
    end else if (q.size() > 0) begin
      exp_v = q.pop_front();
    end else if (rst_req) begin            // R9: reset request wins over start
      for (int i = 0; i < RSTW; i++) q.push_back(6'b001100);
      q.push_back(IDLE_V);
      exp_v = q.pop_front();
    end else if (start) begin
      sent_w = word;
      for (int b = 0; b < NB; b++) begin
        for (int i = 0; i < LO; i++) q.push_back({1'b0, word[b], 4'b0101});
        if (b < NB - 1)
          for (int i = 0; i < HI; i++) q.push_back({1'b1, word[b], 4'b0101});
      end
      for (int i = 0; i < LSU; i++)     q.push_back({1'b1, word[NB-1], 4'b0101});
      for (int i = 0; i < LATHD; i++)   q.push_back({1'b1, word[NB-1], 4'b1101});
      for (int i = 0; i < LATREST; i++) q.push_back(6'b001101);
      q.push_back(6'b001011);
      exp_v = q.pop_front();
    end else begin
      exp_v = IDLE_V;
    end
  end

  // per-cycle comparison and frame decoding, sampled on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      logic [5:0] act;
      act = {sclk_o, sdata_o, slat_o, busy_o, done_o, tgt_rst_n_o};
      checks++;
      if (act !== exp_v) begin
        failures++;
        if (act[5] !== exp_v[5]) $display("FAIL R4 sclk actual=%b expected=%b", act[5], exp_v[5]);
        if (act[4] !== exp_v[4]) $display("FAIL R3 sdata actual=%b expected=%b", act[4], exp_v[4]);
        if (act[3] !== exp_v[3]) $display("FAIL R6 slat actual=%b expected=%b", act[3], exp_v[3]);
        if (act[2] !== exp_v[2]) $display("FAIL R2 busy actual=%b expected=%b", act[2], exp_v[2]);
        if (act[1] !== exp_v[1]) $display("FAIL R7 done actual=%b expected=%b", act[1], exp_v[1]);
        if (act[0] !== exp_v[0]) $display("FAIL R9 tgt_rst_n actual=%b expected=%b", act[0], exp_v[0]);
      end
      if (sclk_o && !prev_sclk) begin
        rx = {sdata_o, rx[NB-1:1]};
        nbits++;
      end
      if (done_o) begin
        chk("R3 received word", 32'(rx), 32'(sent_w));
        chk("R3 bit count", 32'(nbits), 32'(NB));
        chk("R10 data low at end", 32'(sdata_o), 32'd0);
        chk("R7 latch high at done", 32'(slat_o), 32'd1);
        nbits = 0;
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic send(logic [NB-1:0] w);
    @(negedge clk); start = 1'b1; word = w;
    @(negedge clk); start = 1'b0; word = ~w;
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset levels
        chk("R1 reset levels", 32'({sclk_o, sdata_o, slat_o, busy_o, done_o, tgt_rst_n_o}), 32'(IDLE_V));
        // R9: target reset pulse before the first frame
        @(negedge clk); rst_req = 1'b1;
        @(negedge clk); rst_req = 1'b0;
        chk("R9 target reset low", 32'(tgt_rst_n_o), 32'd0);
        while (busy_o) @(negedge clk);
        chk("R9 target reset released", 32'(tgt_rst_n_o), 32'd1);
        // R3 R4 R5 R6 R7 R10: several bit patterns including end bits
        send(11'h5A3);
        send(11'h7FF);
        send(11'h000);
        send(11'h001);
        send(11'h400);
        // R8: start during a frame is ignored
        @(negedge clk); start = 1'b1; word = 11'h155;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1; word = 11'h2AA;
        @(negedge clk); start = 1'b0;
        chk("R8 still busy", 32'(busy_o), 32'd1);
        while (busy_o) @(negedge clk);
        chk("R8 original word kept", 32'(rx), 32'h155);
        // R2: back-to-back start in the cycle after done
        @(negedge clk); start = 1'b1; word = 11'h3C6;
        @(negedge clk); start = 1'b0;
        chk("R2 busy after start", 32'(busy_o), 32'd1);
        chk("R2 latch low after start", 32'(slat_o), 32'd0);
        while (busy_o) @(negedge clk);
        // R9: simultaneous reset request and start; start is dropped
        @(negedge clk); start = 1'b1; rst_req = 1'b1; word = 11'h0F0;
        @(negedge clk); start = 1'b0; rst_req = 1'b0;
        chk("R9 priority over start", 32'({tgt_rst_n_o, slat_o}), 32'b01);
        while (busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R1 idle after all", 32'({sclk_o, sdata_o, slat_o, busy_o}), 32'b0010);
      end
      begin
        wait (cycles > 100000);
        failures++;
        $display("FAIL R2 watchdog actual=%0d expected=<100000", cycles);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule